// File: doc/BRIEF.md
# Phase/Enable H-Bridge Gate Sequencer

This block turns a polarity bit and an enable bit into the four gate commands of an H-bridge that drives a transformer primary. While enable is high, the polarity bit chooses which diagonal pair conducts. While enable is low, every switch is off, and the primary current decays through the body diodes. A converter toggles the polarity bit once per modulation period and uses enable as a chopped on-window. The bridge then steps through four phases in turn: first diagonal, freewheel, second diagonal, freewheel.

The two legs are leg A (high switch `sw_ah_o`, low switch `sw_al_o`) and leg B (high `sw_bh_o`, low `sw_bl_o`). Diagonal A is `sw_ah_o` with `sw_bl_o`. Diagonal B is `sw_al_o` with `sw_bh_o`.

The sequencer has four states:
- `ST_IDLE`: all off, settled.
- `ST_DEAD`: all off, dead time counting.
- `ST_DIAG_A`: diagonal A on.
- `ST_DIAG_B`: diagonal B on.

Its transitions are:
- Leave a settled state (`ST_IDLE`, `ST_DIAG_A`, `ST_DIAG_B`) for `ST_DEAD` when the request differs from that state.
- Restart `ST_DEAD` when the request changes while counting.
- Leave `ST_DEAD` for the requested state once the count completes.

The dead time is `DEAD_CYC` clock cycles, with `DEAD_CYC` of at least 1. Inputs are sampled at every rising clock edge.

Top module: `fb_bridge_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, all four gate outputs are low from the following cycle.
- R2: The two switches of one leg (`sw_ah_o`/`sw_al_o`, `sw_bh_o`/`sw_bl_o`) are never high in the same cycle.
- R3: An edge that samples enable low leaves all four gates low in the next cycle, and polarity changes while enable stays low have no effect on the outputs.
- R4: With enable high and polarity 0, after the dead time the outputs are `sw_ah_o`=1, `sw_bl_o`=1 and the other two low.
- R5: With enable high and polarity 1, after the dead time the outputs are `sw_al_o`=1, `sw_bh_o`=1 and the other two low.
- R6: Every switch-on is preceded by at least `DEAD_CYC` all-off cycles. With a steady request, the new pair turns on exactly `DEAD_CYC` cycles after the first all-off cycle.
- R7: A polarity flip while enable stays high switches the active pair off in the next cycle, then waits out the dead time, then drives the opposite diagonal. It never swaps pairs directly.
- R8: A request change during the dead time restarts the count from the new request. An off-window shorter than the dead time therefore never turns any switch on.
- R9: Toggling polarity every period, with enable high for part of each period, yields the repeating order diagonal A, freewheel, diagonal B, freewheel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| phase_i | input | 1 | Polarity select: 0 = diagonal A, 1 = diagonal B |
| enable_i | input | 1 | High: drive the selected diagonal; low: freewheel |
| sw_ah_o | output | 1 | Leg A high-side gate |
| sw_al_o | output | 1 | Leg A low-side gate |
| sw_bh_o | output | 1 | Leg B high-side gate |
| sw_bl_o | output | 1 | Leg B low-side gate |

## Verification
The hardest case to reach from the ports is a request that changes inside the dead-time window. Examples are a polarity flip that lands a few cycles into the count, or an enable gap shorter than the dead time. In both cases a wrong restart would be hidden by a later steady interval. The stimulus drives inputs on the falling edge with cycle-exact segment lengths. Each segment holds a request for fewer than `DEAD_CYC` cycles before changing it, and a per-cycle reference model predicts the exact cycle where the new pair may turn on.

// File: rtl/fb_bridge_pkg.sv
package fb_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEAD   = 2'd1,
        ST_DIAG_A = 2'd2,
        ST_DIAG_B = 2'd3
    } fb_state_e;

    typedef enum logic [1:0] {
        RQ_OFF = 2'd0,
        RQ_A   = 2'd1,
        RQ_B   = 2'd2
    } fb_req_e;

    typedef struct packed {
        logic ah;
        logic al;
        logic bh;
        logic bl;
    } fb_gates_t;

    // Settled state that serves a given request
    function automatic fb_state_e target_state(fb_req_e r);
        fb_state_e s;
        unique case (r)
            RQ_A:    s = ST_DIAG_A;
            RQ_B:    s = ST_DIAG_B;
            default: s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fb_request_map.sv
module fb_request_map
    import fb_bridge_pkg::*;
(
    input  logic    phase_i,
    input  logic    enable_i,
    output fb_req_e req_o
);
    always_comb begin
        if (!enable_i) begin
            req_o = RQ_OFF;
        end else if (phase_i) begin
            req_o = RQ_B;
        end else begin
            req_o = RQ_A;
        end
    end
endmodule

// File: rtl/fb_dead_timer.sv
module fb_dead_timer #(
    parameter int DEAD_CYC = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(DEAD_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/fb_bridge_fsm.sv
module fb_bridge_fsm
    import fb_bridge_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  fb_req_e   req_i,
    input  logic      done_i,
    output logic      start_o,
    output fb_state_e state_nxt_o
);
    fb_state_e state_q;
    fb_req_e   held_q;
    fb_req_e   held_nxt;

    // Next-state logic
    always_comb begin
        state_nxt_o = state_q;
        held_nxt    = held_q;
        start_o     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DIAG_A, ST_DIAG_B: begin
                if (target_state(req_i) != state_q) begin
                    state_nxt_o = ST_DEAD;
                    held_nxt    = req_i;
                    start_o     = 1'b1;
                end
            end
            ST_DEAD: begin
                if (req_i != held_q) begin
                    held_nxt = req_i;
                    start_o  = 1'b1;
                end else if (done_i) begin
                    state_nxt_o = target_state(held_q);
                end
            end
            default: begin
                state_nxt_o = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            held_q  <= RQ_OFF;
        end else begin
            state_q <= state_nxt_o;
            held_q  <= held_nxt;
        end
    end
endmodule

// File: rtl/fb_gate_decode.sv
module fb_gate_decode
    import fb_bridge_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  fb_state_e state_nxt_i,
    output fb_gates_t gates_o
);
    // Output register, decoded from the next state so no cycle is added
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gates_o <= '0;
        end else begin
            unique case (state_nxt_i)
                ST_DIAG_A: gates_o <= '{ah: 1'b1, al: 1'b0, bh: 1'b0, bl: 1'b1};
                ST_DIAG_B: gates_o <= '{ah: 1'b0, al: 1'b1, bh: 1'b1, bl: 1'b0};
                default:   gates_o <= '0;
            endcase
        end
    end
endmodule

// File: rtl/fb_bridge_ctrl.sv
module fb_bridge_ctrl
    import fb_bridge_pkg::*;
#(
    parameter int DEAD_CYC = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic phase_i,
    input  logic enable_i,
    output logic sw_ah_o,
    output logic sw_al_o,
    output logic sw_bh_o,
    output logic sw_bl_o
);
    fb_req_e   req;
    fb_state_e state_nxt;
    fb_gates_t gates;
    logic      dt_start;
    logic      dt_done;

    fb_request_map map_i (
        .phase_i  (phase_i),
        .enable_i (enable_i),
        .req_o    (req)
    );

    fb_dead_timer #(.DEAD_CYC(DEAD_CYC)) timer_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (dt_start),
        .done_o  (dt_done)
    );

    fb_bridge_fsm fsm_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_i       (req),
        .done_i      (dt_done),
        .start_o     (dt_start),
        .state_nxt_o (state_nxt)
    );

    fb_gate_decode dec_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .state_nxt_i (state_nxt),
        .gates_o     (gates)
    );

    assign sw_ah_o = gates.ah;
    assign sw_al_o = gates.al;
    assign sw_bh_o = gates.bh;
    assign sw_bl_o = gates.bl;
endmodule

// File: rtl/fb_bridge_chk.sv
module fb_bridge_chk #(
    parameter int DEAD_CYC = 10
) (
    input logic clk_i,
    input logic rst_i,
    input logic phase_i,
    input logic enable_i,
    input logic sw_ah_i,
    input logic sw_al_i,
    input logic sw_bh_i,
    input logic sw_bl_i
);
    localparam int CW = $clog2(DEAD_CYC + 1) + 1;
    localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

    logic          any_on;
    logic [CW-1:0] off_run_q;

    assign any_on = sw_ah_i | sw_al_i | sw_bh_i | sw_bl_i;

    // Consecutive all-off cycles seen before the current one
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            off_run_q <= '0;
        end else if (any_on) begin
            off_run_q <= '0;
        end else if (off_run_q < SAT) begin
            off_run_q <= off_run_q + 1'b1;
        end
    end

    a_r1_reset_off: assert property (@(posedge clk_i)
        rst_i |=> !any_on);

    a_r2_leg_a_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        !(sw_ah_i && sw_al_i));

    a_r2_leg_b_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        !(sw_bh_i && sw_bl_i));

    a_r3_disabled_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(enable_i) |-> !any_on);

    a_r4_diag_a: assert property (@(posedge clk_i) disable iff (rst_i)
        sw_ah_i |-> (sw_bl_i && $past(enable_i && !phase_i)));

    a_r5_diag_b: assert property (@(posedge clk_i) disable iff (rst_i)
        sw_bh_i |-> (sw_al_i && $past(enable_i && phase_i)));

    a_r6_dead_time: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(any_on) |-> (off_run_q >= SAT));

    a_r7_no_direct_swap: assert property (@(posedge clk_i) disable iff (rst_i)
        (any_on && $past(any_on)) |-> $stable({sw_ah_i, sw_al_i, sw_bh_i, sw_bl_i}));
endmodule

bind fb_bridge_ctrl fb_bridge_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .phase_i  (phase_i),
    .enable_i (enable_i),
    .sw_ah_i  (sw_ah_o),
    .sw_al_i  (sw_al_o),
    .sw_bh_i  (sw_bh_o),
    .sw_bl_i  (sw_bl_o)
);

// File: tb/fb_bridge_ctrl_tb_top.sv
module fb_bridge_ctrl_tb_top;
    localparam int DEAD = 10;

    typedef struct {
        logic [3:0] gates;   // {ah, al, bh, bl}
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase = 1'b0;
    logic enable = 1'b1;
    logic sw_ah, sw_al, sw_bh, sw_bl;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    exp_t sb_q[$];

    // Reference model: 0 off, 1 diagonal A, 2 diagonal B
    int m_drv = 0;
    bit m_dead = 1'b0;
    int m_held = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    fb_bridge_ctrl #(.DEAD_CYC(DEAD)) dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .phase_i  (phase),
        .enable_i (enable),
        .sw_ah_o  (sw_ah),
        .sw_al_o  (sw_al),
        .sw_bh_o  (sw_bh),
        .sw_bl_o  (sw_bl)
    );

    // Driver: one call per clock cycle, pushes the output expected after the next edge
    task automatic step(input logic ph, input logic en, input logic rs, input string tag);
        int   r;
        exp_t e;
        @(negedge clk);
        phase  = ph;
        enable = en;
        rst    = rs;
        r = !en ? 0 : (ph ? 2 : 1);
        if (rs) begin
            m_drv = 0; m_dead = 1'b0; m_held = 0; m_cnt = 0;
        end else if (!m_dead) begin
            if (r != m_drv) begin
                m_dead = 1'b1; m_held = r; m_cnt = 0;
            end
        end else if (r != m_held) begin
            m_held = r; m_cnt = 0;
        end else if (m_cnt == DEAD - 1) begin
            m_dead = 1'b0; m_drv = m_held;
        end else begin
            m_cnt++;
        end
        e.tag = tag;
        if (m_dead || m_drv == 0) e.gates = 4'b0000;
        else if (m_drv == 1)      e.gates = 4'b1001;
        else                      e.gates = 4'b0110;
        sb_q.push_back(e);
    endtask

    task automatic hold(input logic ph, input logic en, input int n, input string tag);
        for (int i = 0; i < n; i++) step(ph, en, 1'b0, tag);
    endtask

    // Monitor: samples mid-high phase, away from both edges
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [3:0] act;
                e = sb_q.pop_front();
                act = {sw_ah, sw_al, sw_bh, sw_bl};
                n_checks++;
                if (act !== e.gates) begin
                    n_fail++;
                    $display("FAIL %s: gates act=%b exp=%b at %0t", e.tag, act, e.gates, $time);
                end
                n_checks++; // R2 leg exclusivity on every sample
                if ((sw_ah && sw_al) || (sw_bh && sw_bl)) begin
                    n_fail++;
                    $display("FAIL R2: gates act=%b exp=no leg shoot-through", act);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates an active request
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R1");
        // R3: polarity toggling while disabled changes nothing
        for (int i = 0; i < 6; i++) step(logic'(i % 2), 1'b0, 1'b0, "R3");
        // R4 / R6: turn-on to diagonal A after exactly DEAD off cycles
        hold(1'b0, 1'b1, DEAD + 6, "R4");
        // R7 / R5: flip polarity while enabled
        hold(1'b1, 1'b1, DEAD + 6, "R7");
        hold(1'b1, 1'b1, 2, "R5");
        // R3: enable drop switches off at once
        hold(1'b1, 1'b0, DEAD + 4, "R3");
        // R8: polarity flips inside the dead window restart the count
        hold(1'b1, 1'b1, 5, "R8");
        hold(1'b0, 1'b1, 3, "R8");
        hold(1'b1, 1'b1, DEAD + 5, "R8");
        // R8: off-gap shorter than the dead time
        hold(1'b1, 1'b0, 3, "R8");
        hold(1'b1, 1'b1, DEAD + 4, "R6");
        // R9: four-phase pattern, polarity toggling each period
        for (int p = 0; p < 6; p++) begin
            hold(logic'(p % 2), 1'b1, DEAD + 5, "R9");
            hold(logic'(p % 2), 1'b0, DEAD + 3, "R9");
        end
        // R1: reset in the middle of driving
        hold(1'b0, 1'b1, DEAD + 3, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, "R1");
        hold(1'b0, 1'b1, DEAD + 3, "R6");
        // drain scoreboard
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule